// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block takes an incoming Ethernet frame that has already been accepted, delivered as a byte stream with an end-of-frame marker. It stores the frame in a circular buffer in local memory. The memory is organised in 256-byte pages. The ring occupies the pages from a programmable first page up to, but not including, a programmable limit page. A separate boundary page is owned by the host and marks where unread data begins.

The frame bytes are written starting at offset 4 of the current page. The last page used is filled up to offset 255 with zero bytes. When all data and fill bytes are in memory, the block goes back to the frame's first page and writes a four-byte descriptor in offsets 0 to 3. It then pulses a receive-done event and loads its receive status with the success code.

A frame is discarded if any of these holds:
- The receiver is halted when the frame starts.
- The frame is shorter than 60 bytes and short frames are not enabled.
- The page about to be opened is the boundary page.

A discarded frame leaves the current page where it was before the frame began, and no descriptor is written. The host can load the current page while the block is idle.

Top module: `ring_rx_writer`

## Requirements
- R1: Frame byte k (counting from 0) of a frame that begins on page S is written at ring position 4+k. Ring position p maps to page S advanced p/256 times and to offset p mod 256. The memory address is (page·256 + offset) masked to 15 bits.
- R2: Before the first write into each page of a frame, including the frame's first page, the current page is compared with the boundary page. If they are equal, the frame is dropped. No further writes are made, the rest of the stream is consumed, the current page returns to the frame's first page, and no receive-done event occurs.
- R3: Each time a page is completely written, the current page is incremented. If the incremented value equals the limit page, the first page is loaded instead.
- R4: The descriptor at offsets 0, 1, 2 and 3 of the frame's first page holds, in that order:
  - 0x01;
  - the current page after the frame;
  - the low byte of (frame length + 4);
  - the high byte of (frame length + 4).
- R5: The four descriptor writes are the last four memory writes of an accepted frame, issued in offset order 0, 1, 2, 3. An accepted frame makes exactly 256 × (number of pages used) writes.
- R6: After the last frame byte, every remaining offset of that page up to 255 is written with 0x00.
- R7: A frame shorter than 60 bytes is dropped when the short-accept input is 0. Its bytes are written, but no descriptor is written, the current page is unchanged and no event occurs. A frame of exactly 60 bytes, or a short frame while short-accept is 1, is stored normally.
- R8: A frame that starts while the halt input is 1 is consumed from the stream with no memory write, no change of the current page and no event.
- R9: After the last descriptor write is accepted, rx_done is high for exactly one cycle, and from that cycle rx_status reads 0x01.
- R10: A memory write is held, with a stable address, until m_ready is high. The frame stream is back-pressured through s_ready, and no byte is lost or duplicated.
- R11: A page load through cur_wr takes effect on the next cycle while no frame is in progress, and is ignored while a frame is in progress.
- R12: After reset, cur_pg is 0, rx_status is 0, and m_valid, s_ready and rx_done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_first_pg | input | 8 | First page of the ring |
| cfg_limit_pg | input | 8 | Page just past the end of the ring |
| cfg_bnd_pg | input | 8 | Host boundary page |
| cfg_short_ok | input | 1 | Accept frames shorter than 60 bytes |
| cfg_halt | input | 1 | Receiver halted; frames are discarded |
| cur_wr | input | 1 | Load request for the current page |
| cur_wr_pg | input | 8 | Value to load into the current page |
| cur_pg | output | 8 | Current write page |
| s_valid | input | 1 | Frame byte valid |
| s_data | input | 8 | Frame byte |
| s_last | input | 1 | Marks the last byte of the frame |
| s_ready | output | 1 | Frame byte accepted |
| m_valid | output | 1 | Memory write request |
| m_addr | output | 15 | Memory byte address |
| m_data | output | 8 | Memory write data |
| m_ready | input | 1 | Memory accepts the write |
| rx_done | output | 1 | One-cycle pulse when a frame is complete |
| rx_status | output | 8 | Receive status, 0x01 after a stored frame |

## Verification
The hardest situation to reach is a boundary collision part way through a frame. It needs the frame to have already filled its first page, so that the rollback has real writes to undo. The bench places the boundary on the page right after the current one and sends a three-page frame. It then checks that exactly 252 bytes were written, that the current page is back where the frame started, and that a following frame lands normally. Two related cases are also driven:
- a page load issued from a concurrent process while a frame is streaming;
- the whole sequence repeated under pseudo-random memory back-pressure.

// File: rtl/ringw_pkg.sv
package ringw_pkg;
  localparam int PAGE_W    = 8;
  localparam int OFF_W     = 8;
  localparam int ADDR_W    = 15;
  localparam int LEN_W     = 16;
  localparam int HDR_BYTES = 4;
  localparam int MIN_FRAME = 60;
  localparam logic [7:0] RX_OK_CODE = 8'h01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_PAD,
    ST_HDR,
    ST_DRAIN
  } wr_state_t;

  // next ring page, wrapping from the limit back to the first page
  function automatic logic [PAGE_W-1:0] page_step(input logic [PAGE_W-1:0] pg,
                                                  input logic [PAGE_W-1:0] first,
                                                  input logic [PAGE_W-1:0] limit);
    logic [PAGE_W-1:0] n;
    n = pg + 1'b1;
    return (n == limit) ? first : n;
  endfunction

  // byte address of a page/offset pair, cut down to the memory width
  function automatic logic [ADDR_W-1:0] byte_addr(input logic [PAGE_W-1:0] pg,
                                                  input logic [OFF_W-1:0] off);
    return ADDR_W'({pg, off});
  endfunction

  // descriptor byte at offset idx of the frame's first page
  function automatic logic [7:0] hdr_byte(input logic [1:0] idx,
                                          input logic [PAGE_W-1:0] nxt,
                                          input logic [LEN_W-1:0] len);
    case (idx)
      2'd0:    return RX_OK_CODE;
      2'd1:    return 8'(nxt);
      2'd2:    return len[7:0];
      default: return len[15:8];
    endcase
  endfunction

  // total length counts the descriptor, so the threshold is shifted by it
  function automatic logic is_runt(input logic [LEN_W-1:0] total, input logic short_ok);
    return !short_ok && (total < LEN_W'(HDR_BYTES + MIN_FRAME));
  endfunction
endpackage

// File: rtl/ringw_page_ptr.sv
module ringw_page_ptr
  import ringw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PAGE_W-1:0] load_pg,
  input  logic              restore,
  input  logic [PAGE_W-1:0] saved_pg,
  input  logic              adv,
  input  logic [PAGE_W-1:0] first_pg,
  input  logic [PAGE_W-1:0] limit_pg,
  output logic [PAGE_W-1:0] cur_pg
);
  // priority: host load, then rollback, then advance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cur_pg <= '0;
    else if (load)    cur_pg <= load_pg;
    else if (restore) cur_pg <= saved_pg;
    else if (adv)     cur_pg <= page_step(cur_pg, first_pg, limit_pg);
  end

  a_r3_wrap_skips_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && !restore && first_pg != limit_pg) |=> (cur_pg != $past(limit_pg)));

  a_r2_rollback: assert property (@(posedge clk) disable iff (!rst_n)
    (restore && !load) |=> (cur_pg == $past(saved_pg)));

  a_r11_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cur_pg == $past(load_pg)));
endmodule

// File: rtl/ringw_ctrl.sv
module ringw_ctrl
  import ringw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] cfg_bnd_pg,
  input  logic              cfg_short_ok,
  input  logic              cfg_halt,
  input  logic [PAGE_W-1:0] cur_pg,
  input  logic              s_valid,
  input  logic [7:0]        s_data,
  input  logic              s_last,
  output logic              s_ready,
  output logic              m_valid,
  output logic [ADDR_W-1:0] m_addr,
  output logic [7:0]        m_data,
  input  logic              m_ready,
  output logic              adv,
  output logic              restore,
  output logic [PAGE_W-1:0] frame_pg,
  output logic              idle,
  output logic              rx_done,
  output logic [7:0]        rx_status
);
  wr_state_t         state;
  logic [OFF_W-1:0]  off;
  logic [LEN_W-1:0]  len;
  logic [1:0]        hidx;
  logic [PAGE_W-1:0] fstart;
  logic              done_q;
  logic [7:0]        stat_q;

  // named internal events
  logic ev_page_open, ev_overrun, ev_data_fire, ev_pad_fire, ev_page_full, ev_runt;

  assign ev_page_open = (off == '0) || (len == LEN_W'(HDR_BYTES));
  assign ev_overrun   = (state == ST_DATA) && ev_page_open && (cur_pg == cfg_bnd_pg);
  assign ev_data_fire = (state == ST_DATA) && !ev_overrun && s_valid && m_ready;
  assign ev_pad_fire  = (state == ST_PAD) && m_ready;
  assign ev_page_full = (ev_data_fire || ev_pad_fire) && (off == '1);
  assign ev_runt      = ev_data_fire && s_last && is_runt(len + 1'b1, cfg_short_ok);

  assign adv       = ev_page_full;
  assign restore   = ev_overrun || ev_runt;
  assign frame_pg  = fstart;
  assign idle      = (state == ST_IDLE);
  assign rx_done   = done_q;
  assign rx_status = stat_q;

  always_comb begin
    m_valid = 1'b0;
    s_ready = 1'b0;
    m_addr  = byte_addr(cur_pg, off);
    m_data  = s_data;
    case (state)
      ST_DATA: begin
        m_valid = s_valid && !ev_overrun;
        s_ready = m_ready && !ev_overrun;
      end
      ST_PAD: begin
        m_valid = 1'b1;
        m_data  = 8'h00;
      end
      ST_HDR: begin
        m_valid = 1'b1;
        m_addr  = byte_addr(fstart, OFF_W'(hidx));
        m_data  = hdr_byte(hidx, cur_pg, len);
      end
      ST_DRAIN: s_ready = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      off    <= '0;
      len    <= '0;
      hidx   <= '0;
      fstart <= '0;
      done_q <= 1'b0;
      stat_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (s_valid) begin
          fstart <= cur_pg;
          off    <= OFF_W'(HDR_BYTES);
          len    <= LEN_W'(HDR_BYTES);
          hidx   <= '0;
          state  <= cfg_halt ? ST_DRAIN : ST_DATA;
        end
        ST_DATA: begin
          if (ev_overrun) state <= ST_DRAIN;
          else if (ev_data_fire) begin
            off <= off + 1'b1;
            len <= len + 1'b1;
            if (s_last) begin
              if (ev_runt)          state <= ST_IDLE;
              else if (off == '1)   state <= ST_HDR;
              else                  state <= ST_PAD;
            end
          end
        end
        ST_PAD: if (m_ready) begin
          off <= off + 1'b1;
          if (off == '1) state <= ST_HDR;
        end
        ST_HDR: if (m_ready) begin
          hidx <= hidx + 1'b1;
          if (hidx == 2'd3) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
            stat_q <= RX_OK_CODE;
          end
        end
        ST_DRAIN: if (s_valid && s_last) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r2_never_in_bnd: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && (state == ST_DATA || state == ST_PAD)) |-> (cur_pg != cfg_bnd_pg));

  a_r10_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr)));

  a_r9_done_follows_hdr: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> $past(state == ST_HDR && m_ready));

  a_r9_status_ok: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> (rx_status == RX_OK_CODE));
endmodule

// File: rtl/ring_rx_writer.sv
module ring_rx_writer
  import ringw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] cfg_first_pg,
  input  logic [PAGE_W-1:0] cfg_limit_pg,
  input  logic [PAGE_W-1:0] cfg_bnd_pg,
  input  logic              cfg_short_ok,
  input  logic              cfg_halt,
  input  logic              cur_wr,
  input  logic [PAGE_W-1:0] cur_wr_pg,
  output logic [PAGE_W-1:0] cur_pg,
  input  logic              s_valid,
  input  logic [7:0]        s_data,
  input  logic              s_last,
  output logic              s_ready,
  output logic              m_valid,
  output logic [ADDR_W-1:0] m_addr,
  output logic [7:0]        m_data,
  input  logic              m_ready,
  output logic              rx_done,
  output logic [7:0]        rx_status
);
  logic              adv, restore, idle;
  logic [PAGE_W-1:0] frame_pg;

  ringw_page_ptr u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cur_wr && idle),
    .load_pg  (cur_wr_pg),
    .restore  (restore),
    .saved_pg (frame_pg),
    .adv      (adv),
    .first_pg (cfg_first_pg),
    .limit_pg (cfg_limit_pg),
    .cur_pg   (cur_pg)
  );

  ringw_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_bnd_pg   (cfg_bnd_pg),
    .cfg_short_ok (cfg_short_ok),
    .cfg_halt     (cfg_halt),
    .cur_pg       (cur_pg),
    .s_valid      (s_valid),
    .s_data       (s_data),
    .s_last       (s_last),
    .s_ready      (s_ready),
    .m_valid      (m_valid),
    .m_addr       (m_addr),
    .m_data       (m_data),
    .m_ready      (m_ready),
    .adv          (adv),
    .restore      (restore),
    .frame_pg     (frame_pg),
    .idle         (idle),
    .rx_done      (rx_done),
    .rx_status    (rx_status)
  );
endmodule

// File: tb/tb_ring_rx_writer.sv
module tb_ring_rx_writer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_first_pg = 8'd2, cfg_limit_pg = 8'd6, cfg_bnd_pg = 8'h50;
  logic       cfg_short_ok = 1'b0, cfg_halt = 1'b0;
  logic       cur_wr = 1'b0;
  logic [7:0] cur_wr_pg = 8'd0;
  logic [7:0] cur_pg;
  logic       s_valid = 1'b0, s_last = 1'b0, s_ready;
  logic [7:0] s_data = 8'd0;
  logic       m_valid, m_ready;
  logic [14:0] m_addr;
  logic [7:0] m_data;
  logic       rx_done;
  logic [7:0] rx_status;

  int total = 0, bad = 0;
  int rx_cnt = 0, nw = 0, cm = 0;
  bit rdy_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0] mem [0:32767];
  int wlog [0:4095];

  ring_rx_writer dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bstep(input int pg);
    int n = (pg + 1) & 255;
    return (n == int'(cfg_limit_pg)) ? int'(cfg_first_pg) : n;
  endfunction
  function automatic int baddr(input int pg, input int off);
    return ((pg * 256) + off) & 32'h7fff;
  endfunction
  function automatic int pos_page(input int s, input int pos);
    int pg = s;
    for (int i = 0; i < pos / 256; i++) pg = bstep(pg);
    return pg;
  endfunction
  function automatic logic [7:0] dbyte(input int k, input int seed);
    return 8'((k * 13 + seed) & 255);
  endfunction

  // memory side: ready pattern, write capture, event counting
  initial begin
    m_ready = 1'b0;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      m_ready = rdy_mode ? (lfsr[0] | lfsr[1]) : 1'b1;
      #2;
      if (m_valid && m_ready) begin
        mem[m_addr] = m_data;
        if (nw < 4096) wlog[nw] = int'(m_addr);
        nw++;
      end
      if (rx_done) rx_cnt++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic stream(input int len, input int seed);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = dbyte(k, seed); s_last = (k == len - 1);
      #1;
      while (!s_ready) begin @(negedge clk); #1; end
      @(posedge clk);
    end
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic run_frame(input int len, input int seed);
    int s = cm, pages = (len + 4 + 255) / 256, p_over = -1, pg, rx0, exp_w, bad_d, bad_p;
    bit runt = (len < 60) && !cfg_short_ok;
    string tag;
    pg = s;
    for (int p = 0; p < pages; p++) begin
      if (pg == int'(cfg_bnd_pg)) begin p_over = p; break; end
      pg = bstep(pg);
    end
    for (int q = 0; q < pages * 256; q++) mem[baddr(pos_page(s, q), q % 256)] = 8'hxx;
    nw = 0; rx0 = rx_cnt;
    stream(len, seed);
    for (int quiet = 0; quiet < 8; ) begin
      @(negedge clk); #3;
      quiet = m_valid ? 0 : quiet + 1;
    end
    if (cfg_halt || p_over >= 0 || runt) begin
      tag = cfg_halt ? "R8" : (p_over >= 0 ? "R2" : "R7");
      exp_w = cfg_halt ? 0 : (p_over >= 0 ? (p_over == 0 ? 0 : 252 + (p_over - 1) * 256) : len);
      check(cur_pg == 8'(s), {tag, " page unchanged on drop"}, cur_pg, s);
      check(nw == exp_w, {tag, " write count on drop"}, nw, exp_w);
      check(rx_cnt == rx0, {tag, " no done on drop"}, rx_cnt - rx0, 0);
    end else begin
      pg = s;
      for (int p = 0; p < pages; p++) pg = bstep(pg);
      cm = pg;
      check(cur_pg == 8'(pg), "R3 next page with wrap", cur_pg, pg);
      check(mem[baddr(s, 0)] === 8'h01, "R4 status byte", mem[baddr(s, 0)], 1);
      check(mem[baddr(s, 1)] === 8'(pg), "R4 next page byte", mem[baddr(s, 1)], pg);
      check(mem[baddr(s, 2)] === 8'((len + 4) & 255), "R4 length low", mem[baddr(s, 2)], (len + 4) & 255);
      check(mem[baddr(s, 3)] === 8'((len + 4) >> 8), "R4 length high", mem[baddr(s, 3)], (len + 4) >> 8);
      bad_d = 0;
      for (int k = 0; k < len; k++)
        if (mem[baddr(pos_page(s, 4 + k), (4 + k) % 256)] !== dbyte(k, seed)) bad_d++;
      check(bad_d == 0, "R1 R10 data placement", bad_d, 0);
      bad_p = 0;
      for (int q = len + 4; q < pages * 256; q++)
        if (mem[baddr(pos_page(s, q), q % 256)] !== 8'h00) bad_p++;
      check(bad_p == 0, "R6 zero padding", bad_p, 0);
      check(nw == pages * 256, "R5 write count", nw, pages * 256);
      for (int h = 0; h < 4; h++)
        check(nw >= 4 && wlog[nw - 4 + h] == baddr(s, h), "R5 descriptor last and ordered",
              wlog[nw - 4 + h], baddr(s, h));
      check(rx_cnt == rx0 + 1, "R9 single done pulse", rx_cnt - rx0, 1);
      check(rx_status == 8'h01, "R9 status code", rx_status, 1);
    end
  endtask

  task automatic load_page(input int pg);
    @(negedge clk); cur_wr = 1'b1; cur_wr_pg = 8'(pg);
    @(negedge clk); cur_wr = 1'b0;
    #1 check(cur_pg == 8'(pg), "R11 load while idle", cur_pg, pg);
    cm = pg;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cur_pg == 8'd0, "R12 reset page", cur_pg, 0);
    check(!m_valid && !s_ready && !rx_done, "R12 reset outputs", {m_valid, s_ready, rx_done}, 0);
    check(rx_status == 8'd0, "R12 reset status", rx_status, 0);
    rst_n = 1'b1;
    load_page(2);
    // always-ready sweep, short-frame threshold, exact page fill
    run_frame(100, 3);
    run_frame(60, 7);
    run_frame(59, 11);
    run_frame(252, 5);
    run_frame(253, 9);
    // back-pressure sweep with ring wrap
    rdy_mode = 1'b1;
    run_frame(600, 21);
    run_frame(1, 2);
    cfg_short_ok = 1'b1;
    run_frame(59, 4);
    run_frame(1, 6);
    run_frame(508, 8);
    run_frame(600, 10);
    // halted receiver
    cfg_halt = 1'b1;
    run_frame(100, 12);
    cfg_halt = 1'b0;
    // boundary collision on a later page, then on the first page
    cfg_bnd_pg = 8'(bstep(cm));
    run_frame(600, 14);
    cfg_bnd_pg = 8'(cm);
    run_frame(100, 15);
    cfg_bnd_pg = 8'h50;
    run_frame(100, 16);
    // load attempt while a frame streams must be ignored (R11)
    fork
      run_frame(400, 17);
      begin
        repeat (30) @(negedge clk);
        cur_wr = 1'b1; cur_wr_pg = 8'h40;
        @(negedge clk); cur_wr = 1'b0;
      end
    join
    // pages above the address width are masked (R1)
    cfg_first_pg = 8'h85; cfg_limit_pg = 8'h88;
    load_page(8'h85);
    run_frame(300, 18);
    run_frame(600, 19);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule